// File: doc/BRIEF.md
# Dual-Window Bank-Switched Byte Memory

This block is a byte-wide storage peripheral built from a set of equal-size banks. A host sees two adjacent address windows on the data port. Each window is backed by whichever bank its own select register names. The host can therefore reach any two banks of a store larger than its address range, and can change which banks those are between accesses.

A second, small register port reads and writes the two select registers. The number of banks comes from a requested count that the block normalizes. The bank size is a power of two set by a parameter, so the nominal 512 KiB bank can be shrunk for simulation.

A data access outside the two windows, or through a select register that names a bank that does not exist, is refused. The block raises a one-cycle error, drops a write and answers a read with 0xFF.

Top module: `bankmem_dual_window`

## Requirements
- R1: The bank count is the requested count clamped to 2..256 and then, if odd, raised by one. With a request of 5 the count is 6: bank index 5 is usable and index 6 is refused.
- R2: The data address is BANK_AW+2 bits wide. Addresses 0..2^BANK_AW-1 use window 0, addresses 2^BANK_AW..2^(BANK_AW+1)-1 use window 1, and higher addresses are outside both windows.
- R3: A byte is stored at physical location (selected bank × 2^BANK_AW) + (address mod 2^BANK_AW), for both reads and writes.
- R4: After reset, the window 0 select register holds 0 and the window 1 select register holds 1.
- R5: Control offset 0 is the window 0 select register and offset 1 is the window 1 select register. Each is 8-bit unsigned, a write replaces it, and a read returns it combinationally.
- R6: A control read at any other offset returns 0xFF, and a control write at any other offset changes neither select register.
- R7: A data access outside both windows raises the error output for exactly the cycle after the request. A write is then dropped, and a read returns 0xFF with the read-valid strobe.
- R8: A data access through a window whose select register holds an index at or above the bank count is refused in the same way as R7.
- R9: Both windows may name the same bank. A byte written through one window is then returned by a read through the other.
- R10: A data read returns its byte, with read-valid high, in the cycle after the request. Writes and idle cycles leave read-valid and the error output low.
- R11: A control write takes effect for a data access made in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_req | input | 1 | Data access request |
| d_we | input | 1 | Data access is a write |
| d_addr | input | BANK_AW+2 | Data byte address |
| d_wdata | input | 8 | Data write byte |
| d_rdata | output | 8 | Data read byte |
| d_rvalid | output | 1 | Read byte valid, one cycle after the request |
| d_err | output | 1 | Refused access, one cycle after the request |
| c_we | input | 1 | Control register write |
| c_addr | input | CTL_AW | Control register offset |
| c_wdata | input | 8 | Control write value |
| c_rdata | output | 8 | Control read value |

## Verification
The bench builds the block with an 8-byte bank and a requested count of 5. This makes the store six banks, 48 bytes in all, so every byte can be preloaded and checked. The odd-count round-up becomes visible at bank 5, and select values up to 7 reach past the last bank. The 5-bit data address covers both windows and the refused upper half. Random mixes of select writes, including writes to unused offsets, and of reads and writes over the whole address range therefore hit aliasing, bank remapping and both error causes often.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;

  localparam int unsigned MIN_BANKS = 2;
  localparam int unsigned MAX_BANKS = 256;

  // Clamp the requested bank count and round an odd result up to even.
  function automatic int unsigned norm_bank_count(input int unsigned req);
    int unsigned c;
    if (req < MIN_BANKS)      c = MIN_BANKS;
    else if (req > MAX_BANKS) c = MAX_BANKS;
    else                      c = req;
    if ((c % 2) != 0) c = c + 1;
    return c;
  endfunction

  // Width needed to index a count of items (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w = w + 1;
    return w;
  endfunction

endpackage

// File: rtl/bank_map_regs.sv
module bank_map_regs #(
  parameter int CTL_AW = 4,
  parameter int NWIN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_we,
  input  logic [CTL_AW-1:0] c_addr,
  input  logic [7:0]        c_wdata,
  output logic [7:0]        c_rdata,
  output logic [7:0]        win_sel [NWIN]
);

  logic [NWIN-1:0] hit_vec;
  logic            ctl_unmapped;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit_vec[g] = (c_addr == CTL_AW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)                   win_sel[g] <= 8'(g);
      else if (c_we && hit_vec[g])  win_sel[g] <= c_wdata;
    end

    // R5: a write at this offset replaces the register
    a_r5_write_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (c_we && c_addr == CTL_AW'(g)) |=> (win_sel[g] == $past(c_wdata)));
  end

  assign ctl_unmapped = (hit_vec == '0);

  always_comb begin
    c_rdata = 8'hFF;
    for (int i = 0; i < NWIN; i++)
      if (hit_vec[i]) c_rdata = win_sel[i];
  end

  // R6: writes at unused offsets leave the registers alone
  a_r6_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && ctl_unmapped) |=> ($stable(win_sel[0]) && $stable(win_sel[NWIN-1])));

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int BANK_AW = 4,
  parameter int NBANKS  = 4,
  parameter int PHYS_AW = 6,
  parameter int NWIN    = 2
) (
  input  logic [BANK_AW+1:0]  d_addr,
  input  logic [7:0]          win_sel [NWIN],
  output logic [PHYS_AW-1:0]  phys,
  output logic                hit
);

  localparam int DEPTH = NBANKS << BANK_AW;

  function automatic logic [PHYS_AW-1:0] join_addr(input logic [7:0] bank,
                                                   input logic [BANK_AW-1:0] off);
    return (PHYS_AW'(bank) << BANK_AW) | PHYS_AW'(off);
  endfunction

  logic             outside;
  logic             win;
  logic [7:0]       bank;
  logic             bank_bad;

  assign outside  = d_addr[BANK_AW+1];
  assign win      = d_addr[BANK_AW];
  assign bank     = win_sel[int'(win)];
  assign bank_bad = (int'(bank) >= NBANKS);
  assign hit      = !outside && !bank_bad;
  assign phys     = join_addr(bank, d_addr[BANK_AW-1:0]);

  // R3: an accepted access always lands inside the store
  always_comb begin
    if (hit) a_r3_in_store: assert (int'(phys) < DEPTH);
  end

endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end

endmodule

// File: rtl/bankmem_dual_window.sv
module bankmem_dual_window #(
  parameter int BANK_AW   = 4,
  parameter int REQ_BANKS = 4,
  parameter int CTL_AW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               d_req,
  input  logic               d_we,
  input  logic [BANK_AW+1:0] d_addr,
  input  logic [7:0]         d_wdata,
  output logic [7:0]         d_rdata,
  output logic               d_rvalid,
  output logic               d_err,
  input  logic               c_we,
  input  logic [CTL_AW-1:0]  c_addr,
  input  logic [7:0]         c_wdata,
  output logic [7:0]         c_rdata
);

  localparam int NWIN    = 2;
  localparam int NBANKS  = int'(bankmem_pkg::norm_bank_count(REQ_BANKS));
  localparam int PHYS_AW = BANK_AW + int'(bankmem_pkg::idx_width(NBANKS));
  localparam int DEPTH   = NBANKS << BANK_AW;

  logic [7:0]         win_sel [NWIN];
  logic [PHYS_AW-1:0] phys;
  logic               hit;
  logic               acc_refused;
  logic               st_we, st_re;
  logic [7:0]         st_rdata;
  logic               rvalid_q, err_q, rd_bad_q;

  bank_map_regs #(.CTL_AW(CTL_AW), .NWIN(NWIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .c_we(c_we), .c_addr(c_addr),
    .c_wdata(c_wdata), .c_rdata(c_rdata), .win_sel(win_sel)
  );

  bank_xlate #(.BANK_AW(BANK_AW), .NBANKS(NBANKS), .PHYS_AW(PHYS_AW), .NWIN(NWIN)) u_xlate (
    .d_addr(d_addr), .win_sel(win_sel), .phys(phys), .hit(hit)
  );

  assign acc_refused = d_req && !hit;
  assign st_we       = d_req &&  d_we && hit;
  assign st_re       = d_req && !d_we && hit;

  bank_store #(.DEPTH(DEPTH), .AW(PHYS_AW)) u_store (
    .clk(clk), .we(st_we), .re(st_re), .addr(phys),
    .wdata(d_wdata), .rdata(st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rd_bad_q <= 1'b0;
    end else begin
      rvalid_q <= d_req && !d_we;
      err_q    <= acc_refused;
      rd_bad_q <= acc_refused && !d_we;
    end
  end

  assign d_rvalid = rvalid_q;
  assign d_err    = err_q;
  assign d_rdata  = rd_bad_q ? 8'hFF : st_rdata;

  // R7: an access beyond both windows is refused the next cycle
  a_r7_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_we && d_addr[BANK_AW+1]) |=> (d_err && d_rvalid && d_rdata == 8'hFF));

  // R8: a read through a select naming a missing bank is refused
  a_r8_bad_bank_read: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_we && !d_addr[BANK_AW+1] && int'(win_sel[int'(d_addr[BANK_AW])]) >= NBANKS)
      |=> (d_err && d_rdata == 8'hFF));

  // R10: reads strobe read-valid one cycle later
  a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_we) |=> d_rvalid);

  // R10: writes and idle cycles produce no strobe and no error
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_req || d_we) |=> !d_rvalid);

  a_r7_err_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    !d_req |=> !d_err);

endmodule

// File: tb/bankmem_dual_window_test.sv
`timescale 1ns/1ps
module bankmem_dual_window_test;

  localparam int BANK_AW = 3;
  localparam int REQ     = 5;
  localparam int CTL_AW  = 4;
  localparam int BSZ     = 1 << BANK_AW;
  localparam int AW      = BANK_AW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic d_req = 0, d_we = 0;
  logic [AW-1:0] d_addr = '0;
  logic [7:0] d_wdata = '0, d_rdata, c_wdata = '0, c_rdata;
  logic d_rvalid, d_err, c_we = 0;
  logic [CTL_AW-1:0] c_addr = '0;

  always #2.5 clk = ~clk;

  bankmem_dual_window #(.BANK_AW(BANK_AW), .REQ_BANKS(REQ), .CTL_AW(CTL_AW)) uut (
    .clk(clk), .rst_n(rst_n), .d_req(d_req), .d_we(d_we), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rdata), .d_rvalid(d_rvalid), .d_err(d_err),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // Bench's own statement of the bank count rule (R1).
  function automatic int exp_banks(int r);
    int n = (r > 256) ? 256 : r;
    if (n < 2) n = 2;
    return n + (n & 1);
  endfunction
  localparam int NB = exp_banks(REQ);

  logic [7:0] model [NB*BSZ];
  int msel [2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected outcome of a data access: -1 means refused.
  function automatic int exp_loc(int a);
    int b;
    if (a >= 2*BSZ) return -1;
    b = msel[a / BSZ];
    if (b >= NB) return -1;
    return b*BSZ + (a % BSZ);
  endfunction

  task automatic ctl_write(input int off, input int v);
    @(negedge clk); c_we = 1; c_addr = CTL_AW'(off); c_wdata = 8'(v);
    @(negedge clk); c_we = 0;
    if (off < 2) msel[off] = v;
  endtask

  task automatic ctl_read_chk(input int off, input string tag);
    int e;
    @(negedge clk); c_addr = CTL_AW'(off); #1;
    e = (off < 2) ? msel[off] : 8'hFF;
    chk(c_rdata == 8'(e), tag, c_rdata, e);
  endtask

  task automatic dwrite(input int a, input int v, input string tag);
    int loc = exp_loc(a);
    @(negedge clk); d_req = 1; d_we = 1; d_addr = AW'(a); d_wdata = 8'(v);
    @(negedge clk); d_req = 0; d_we = 0;
    chk(d_err == (loc < 0) && !d_rvalid, tag, {d_err, d_rvalid}, {loc < 0, 1'b0});
    if (loc >= 0) model[loc] = 8'(v);
  endtask

  task automatic dread(input int a, input string tag);
    int loc = exp_loc(a);
    int e = (loc < 0) ? 8'hFF : model[loc];
    @(negedge clk); d_req = 1; d_we = 0; d_addr = AW'(a);
    @(negedge clk); d_req = 0;
    chk(d_rvalid && d_err == (loc < 0) && d_rdata == 8'(e), tag, d_rdata, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    msel[0] = 0; msel[1] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R4 reset state, R6 unused offsets read all ones
    ctl_read_chk(0, "R4 sel0 reset");
    ctl_read_chk(1, "R4 sel1 reset");
    ctl_read_chk(2, "R6 unused read");
    ctl_read_chk(15, "R6 unused read");
    @(negedge clk); #1;
    chk(!d_rvalid && !d_err, "R10 idle quiet", {d_rvalid, d_err}, 0);

    // R3 preload every bank through window 0 and window 1 alternately
    for (int b = 0; b < NB; b++) begin
      ctl_write(b % 2, b);
      for (int o = 0; o < BSZ; o++) dwrite((b % 2)*BSZ + o, (b*37 + o*11 + 5) & 255, "R3 preload");
    end
    // R3 readback through the other window
    for (int b = 0; b < NB; b++) begin
      ctl_write(1 - (b % 2), b);
      for (int o = 0; o < BSZ; o++) dread((1 - (b % 2))*BSZ + o, "R3 readback");
    end

    // R1 last bank usable, first missing bank refused
    ctl_write(0, NB - 1);
    dread(3, "R1 last bank");
    ctl_write(0, NB);
    dread(3, "R1 bank count edge");
    dwrite(4, 8'h99, "R8 refused write");
    ctl_write(0, 255);
    dread(0, "R8 index 255");

    // R2/R7 outside both windows
    ctl_write(0, 2);
    dread(2*BSZ, "R7 first outside");
    dwrite(4*BSZ - 1, 8'h5A, "R7 outside write");
    dread(BSZ - 1, "R2 window0 top");
    dread(BSZ, "R2 window1 bottom");

    // R6 unused write leaves both selects alone
    ctl_write(3, 4);
    ctl_read_chk(0, "R6 sel0 after unused write");
    ctl_read_chk(1, "R6 sel1 after unused write");

    // R9 aliasing
    ctl_write(0, 3); ctl_write(1, 3);
    dwrite(5, 8'hC3, "R9 alias write");
    dread(BSZ + 5, "R9 alias read");

    // R11 select write then read in the next cycle
    @(negedge clk); c_we = 1; c_addr = 0; c_wdata = 8'd4;
    @(negedge clk); c_we = 0; d_req = 1; d_we = 0; d_addr = AW'(2);
    msel[0] = 4;
    @(negedge clk); d_req = 0;
    chk(d_rvalid && !d_err && d_rdata == model[4*BSZ + 2], "R11 next-cycle remap",
        d_rdata, model[4*BSZ + 2]);
    ctl_read_chk(0, "R5 sel0 readback");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 2)      ctl_write($urandom_range(0, 3), $urandom_range(0, NB + 1));
      else if (k < 5) dwrite($urandom_range(0, 4*BSZ - 1), $urandom_range(0, 255), "R3 random write");
      else if (k < 9) dread($urandom_range(0, 4*BSZ - 1), "R3 random read");
      else            ctl_read_chk($urandom_range(0, 5), "R5 random ctl read");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule